// File: doc/BRIEF.md
# Socket Command and Pointer Controller

This block keeps the control state of a small set of network sockets (four by default) behind a byte-wide host register port. Each socket has a protocol mode byte, a command byte and a status byte. It also has three 16-bit ring pointers: transmit read, transmit write and receive read. The host writes a command byte, and the block runs it in the same cycle. OPEN sets the status from the protocol nibble and clears the pointers. CLOSE clears the status. SEND drains the whole transmit ring and requests transmission. RECV takes a snapshot of the receive backlog.

Packet movement is outside the block. A transmit request leaves as a one-cycle pulse that carries the socket number, the ring offset where the data starts and the byte count. Received data comes in as a free-running receive write pointer for each socket. Ring sizes come in as 2-bit size codes for each socket. A code of c means a ring of 1024 << c bytes. Read-back values are computed with arithmetic modulo the ring size.

Top module: `socket_cmd_ctrl`

## Requirements
- R1: Socket n occupies host addresses 0x0400 + n*0x100. Its offsets are: 0x00 mode, 0x01 command and 0x03 status. Mode and command read back the last byte written to them. Unused offsets, and any address outside the socket windows, read 0 and ignore writes.
- R2: `host_rdata` carries the addressed byte in the cycle after `host_rd` is sampled high, and is 0 in any cycle after a cycle without a read.
- R3: Writing 0x01 (OPEN) sets status to 0x32 when the mode's low nibble is 3, and to 0x42 when it is 4. Any other nibble leaves the status unchanged. OPEN always clears the transmit read, transmit write and receive read pointers and the stored received size. It also takes the current receive write pointer as the new origin, so the receive backlog starts from zero.
- R4: Writing 0x10 (CLOSE) sets status to 0x00.
- R5: Writing 0x20 (SEND) copies the transmit write pointer into the transmit read pointer. If the status is 0x32 or 0x42, `send_valid` is high for exactly the cycle after the write. In that cycle `send_sock` is the socket, `send_start` is the old read pointer masked by (size-1), and `send_len` is (write - read) mod size. With any other status, no pulse is sent.
- R6: Writing 0x40 (RECV) loads the received size with (rx_wr_ptr - origin - receive read) mod size. The register holds that value until the next RECV or OPEN, even if the receive write pointer moves.
- R7: Pointers are big-endian, with the high byte at the lower offset: transmit read 0x22/0x23, transmit write 0x24/0x25, receive read 0x28/0x29. Transmit write and receive read are host-writable byte by byte. Transmit read is read-only, and host writes to it are ignored.
- R8: Offsets 0x20/0x21 return the transmit free size live: size - ((write - read) mod size), where size = 1024 << `tx_size_code[2n+1:2n]`. The receive ring size uses `rx_size_code` in the same way.
- R9: After reset, every status, mode, command, pointer and received size is 0, `host_rdata` is 0 and `send_valid` is low.
- R10: Command bytes other than 0x01, 0x10, 0x20 and 0x40 are stored in the command register and change no other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host byte write strobe |
| host_rd | input | 1 | Host byte read strobe |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data, valid one cycle after `host_rd` |
| tx_size_code | input | 8 | Transmit ring size code, 2 bits per socket |
| rx_size_code | input | 8 | Receive ring size code, 2 bits per socket |
| rx_wr_ptr | input | 64 | Receive write pointer from the receive path, 16 bits per socket |
| send_valid | output | 1 | One-cycle transmit request |
| send_sock | output | 2 | Socket of the transmit request |
| send_start | output | 16 | Masked ring offset where the data starts |
| send_len | output | 16 | Number of bytes to transmit |

## Verification
The bench targets pointer wrap-around, where the write pointer is numerically below the read pointer. A design that skipped the modular correction would report free or received sizes above the ring size, or negative ones. It checks that RECV is the only thing that refreshes the received size. A live computation would change the value as soon as the receive write pointer moves. SEND is checked on a closed socket: the pointer must move with no request pulse. OPEN is checked with a protocol nibble that is not raw: the status must stay as it was. Writes to the read-only transmit read pointer and unknown command bytes are checked through read-back, to catch decode that leaks into neighbouring state.

// File: rtl/sockctl_pkg.sv
package sockctl_pkg;
  localparam int unsigned PTR_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned MIN_LG = 10;

  // per-socket register offsets
  localparam logic [7:0] OFF_MODE   = 8'h00;
  localparam logic [7:0] OFF_CMD    = 8'h01;
  localparam logic [7:0] OFF_STAT   = 8'h03;
  localparam logic [7:0] OFF_FREE_H = 8'h20;
  localparam logic [7:0] OFF_FREE_L = 8'h21;
  localparam logic [7:0] OFF_TXR_H  = 8'h22;
  localparam logic [7:0] OFF_TXR_L  = 8'h23;
  localparam logic [7:0] OFF_TXW_H  = 8'h24;
  localparam logic [7:0] OFF_TXW_L  = 8'h25;
  localparam logic [7:0] OFF_RSZ_H  = 8'h26;
  localparam logic [7:0] OFF_RSZ_L  = 8'h27;
  localparam logic [7:0] OFF_RXR_H  = 8'h28;
  localparam logic [7:0] OFF_RXR_L  = 8'h29;

  typedef enum logic [7:0] {
    CMD_OPEN  = 8'h01,
    CMD_CLOSE = 8'h10,
    CMD_SEND  = 8'h20,
    CMD_RECV  = 8'h40
  } sock_cmd_e;

  localparam logic [3:0] PROTO_IPRAW  = 4'h3;
  localparam logic [3:0] PROTO_MACRAW = 4'h4;

  localparam logic [7:0] ST_CLOSED = 8'h00;
  localparam logic [7:0] ST_IPRAW  = 8'h32;
  localparam logic [7:0] ST_MACRAW = 8'h42;

  typedef logic [PTR_W-1:0] ptr_t;
endpackage

// File: rtl/sock_addr_dec.sv
module sock_addr_dec #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned NUM_SOCK  = 4,
  parameter int unsigned BASE      = 16'h0400,
  parameter int unsigned STRIDE_LG = 8,
  localparam int unsigned IDX_W    = $clog2(NUM_SOCK)
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic                 hit,
  output logic [IDX_W-1:0]     idx,
  output logic [STRIDE_LG-1:0] off
);
  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] slot;

  always_comb begin
    rel  = addr - ADDR_W'(BASE);
    slot = rel >> STRIDE_LG;
    hit  = (slot < ADDR_W'(NUM_SOCK));
    idx  = rel[STRIDE_LG +: IDX_W];
    off  = rel[STRIDE_LG-1:0];
  end
endmodule

// File: rtl/sock_ring_calc.sv
module sock_ring_calc #(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned CODE_W = 2,
  parameter int unsigned MIN_LG = 10
) (
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [PTR_W-1:0]  rd_ptr,
  input  logic [CODE_W-1:0] code,
  output logic [PTR_W-1:0]  size,
  output logic [PTR_W-1:0]  mask,
  output logic [PTR_W-1:0]  used
);
  always_comb begin
    size = PTR_W'(1) << (MIN_LG + 32'(code));
    mask = size - PTR_W'(1);
    // two's complement difference masked to the ring = diff (+size if negative)
    used = (wr_ptr - rd_ptr) & mask;
  end
endmodule

// File: rtl/sock_slot.sv
module sock_slot
  import sockctl_pkg::*;
#(
  parameter int unsigned CODE_W = 2,
  parameter int unsigned OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_sel,
  input  logic [OFF_W-1:0]  off,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CODE_W-1:0] tx_code,
  input  logic [CODE_W-1:0] rx_code,
  input  ptr_t              rx_wr_ptr,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              send_fire,
  output ptr_t              send_start,
  output ptr_t              send_len
);
  logic [BYTE_W-1:0] mode_q, cmd_q, stat_q;
  ptr_t txr_q, txw_q, rxr_q, rsz_q, origin_q;
  ptr_t tx_size, tx_mask, tx_used;
  ptr_t rx_size, rx_mask, rx_used;
  ptr_t rx_fill, tx_free;
  logic [7:0] off8;

  assign off8    = 8'(off);
  assign rx_fill = rx_wr_ptr - origin_q;
  assign tx_free = tx_size - tx_used;

  sock_ring_calc #(.PTR_W(PTR_W), .CODE_W(CODE_W), .MIN_LG(MIN_LG)) u_tx_ring (
    .wr_ptr(txw_q), .rd_ptr(txr_q), .code(tx_code),
    .size(tx_size), .mask(tx_mask), .used(tx_used)
  );

  sock_ring_calc #(.PTR_W(PTR_W), .CODE_W(CODE_W), .MIN_LG(MIN_LG)) u_rx_ring (
    .wr_ptr(rx_fill), .rd_ptr(rxr_q), .code(rx_code),
    .size(rx_size), .mask(rx_mask), .used(rx_used)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= '0;
      cmd_q      <= '0;
      stat_q     <= ST_CLOSED;
      txr_q      <= '0;
      txw_q      <= '0;
      rxr_q      <= '0;
      rsz_q      <= '0;
      origin_q   <= '0;
      send_fire  <= 1'b0;
      send_start <= '0;
      send_len   <= '0;
    end else begin
      send_fire <= 1'b0;
      if (wr_sel) begin
        unique case (off8)
          OFF_MODE:  mode_q <= wdata;
          OFF_CMD: begin
            cmd_q <= wdata;
            case (wdata)
              CMD_OPEN: begin
                if (mode_q[3:0] == PROTO_IPRAW)       stat_q <= ST_IPRAW;
                else if (mode_q[3:0] == PROTO_MACRAW) stat_q <= ST_MACRAW;
                txr_q    <= '0;
                txw_q    <= '0;
                rxr_q    <= '0;
                rsz_q    <= '0;
                origin_q <= rx_wr_ptr;
              end
              CMD_CLOSE: stat_q <= ST_CLOSED;
              CMD_SEND: begin
                txr_q <= txw_q;
                if (stat_q == ST_IPRAW || stat_q == ST_MACRAW) begin
                  send_fire  <= 1'b1;
                  send_start <= txr_q & tx_mask;
                  send_len   <= tx_used;
                end
              end
              CMD_RECV:  rsz_q <= rx_used;
              default: ;
            endcase
          end
          OFF_TXW_H: txw_q[15:8] <= wdata;
          OFF_TXW_L: txw_q[7:0]  <= wdata;
          OFF_RXR_H: rxr_q[15:8] <= wdata;
          OFF_RXR_L: rxr_q[7:0]  <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (off8)
      OFF_MODE:   rd_byte = mode_q;
      OFF_CMD:    rd_byte = cmd_q;
      OFF_STAT:   rd_byte = stat_q;
      OFF_FREE_H: rd_byte = tx_free[15:8];
      OFF_FREE_L: rd_byte = tx_free[7:0];
      OFF_TXR_H:  rd_byte = txr_q[15:8];
      OFF_TXR_L:  rd_byte = txr_q[7:0];
      OFF_TXW_H:  rd_byte = txw_q[15:8];
      OFF_TXW_L:  rd_byte = txw_q[7:0];
      OFF_RSZ_H:  rd_byte = rsz_q[15:8];
      OFF_RSZ_L:  rd_byte = rsz_q[7:0];
      OFF_RXR_H:  rd_byte = rxr_q[15:8];
      OFF_RXR_L:  rd_byte = rxr_q[7:0];
      default:    rd_byte = '0;
    endcase
  end
endmodule

// File: rtl/socket_cmd_ctrl.sv
module socket_cmd_ctrl
  import sockctl_pkg::*;
#(
  parameter int unsigned NUM_SOCK  = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SOCK_BASE = 16'h0400,
  parameter int unsigned STRIDE_LG = 8,
  parameter int unsigned CODE_W    = 2,
  localparam int unsigned IDX_W    = $clog2(NUM_SOCK)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       host_wr,
  input  logic                       host_rd,
  input  logic [ADDR_W-1:0]          host_addr,
  input  logic [BYTE_W-1:0]          host_wdata,
  output logic [BYTE_W-1:0]          host_rdata,
  input  logic [NUM_SOCK*CODE_W-1:0] tx_size_code,
  input  logic [NUM_SOCK*CODE_W-1:0] rx_size_code,
  input  logic [NUM_SOCK*PTR_W-1:0]  rx_wr_ptr,
  output logic                       send_valid,
  output logic [IDX_W-1:0]           send_sock,
  output logic [PTR_W-1:0]           send_start,
  output logic [PTR_W-1:0]           send_len
);
  logic                 dec_hit;
  logic [IDX_W-1:0]     dec_idx;
  logic [STRIDE_LG-1:0] dec_off;

  logic [BYTE_W-1:0] slot_rd    [NUM_SOCK];
  logic              slot_fire  [NUM_SOCK];
  ptr_t              slot_start [NUM_SOCK];
  ptr_t              slot_len   [NUM_SOCK];

  sock_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_SOCK(NUM_SOCK), .BASE(SOCK_BASE), .STRIDE_LG(STRIDE_LG)
  ) u_dec (
    .addr(host_addr), .hit(dec_hit), .idx(dec_idx), .off(dec_off)
  );

  for (genvar g = 0; g < NUM_SOCK; g++) begin : g_slot
    logic sel;
    assign sel = host_wr && dec_hit && (dec_idx == IDX_W'(g));
    sock_slot #(.CODE_W(CODE_W), .OFF_W(STRIDE_LG)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .wr_sel    (sel),
      .off       (dec_off),
      .wdata     (host_wdata),
      .tx_code   (tx_size_code[g*CODE_W +: CODE_W]),
      .rx_code   (rx_size_code[g*CODE_W +: CODE_W]),
      .rx_wr_ptr (rx_wr_ptr[g*PTR_W +: PTR_W]),
      .rd_byte   (slot_rd[g]),
      .send_fire (slot_fire[g]),
      .send_start(slot_start[g]),
      .send_len  (slot_len[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else if (host_rd && dec_hit) host_rdata <= slot_rd[dec_idx];
    else host_rdata <= '0;
  end

  // only one command write per cycle, so at most one slot fires
  always_comb begin
    send_valid = 1'b0;
    send_sock  = '0;
    send_start = '0;
    send_len   = '0;
    for (int i = 0; i < NUM_SOCK; i++) begin
      if (slot_fire[i]) begin
        send_valid = 1'b1;
        send_sock  = IDX_W'(i);
        send_start = slot_start[i];
        send_len   = slot_len[i];
      end
    end
  end
endmodule

// File: rtl/sockctl_chk.sv
module sockctl_chk #(
  parameter int unsigned NUM_SOCK  = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SOCK_BASE = 16'h0400,
  parameter int unsigned STRIDE_LG = 8,
  parameter int unsigned CODE_W    = 2,
  localparam int unsigned IDX_W    = $clog2(NUM_SOCK),
  localparam int unsigned MAX_LEN  = 1 << (10 + (1 << CODE_W) - 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr,
  input logic              host_rd,
  input logic [ADDR_W-1:0] host_addr,
  input logic [7:0]        host_wdata,
  input logic [7:0]        host_rdata,
  input logic              send_valid,
  input logic [IDX_W-1:0]  send_sock,
  input logic [15:0]       send_len
);
  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (host_rdata == 8'h00 && !send_valid));

  p_rdata_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(host_rd) |-> host_rdata == 8'h00);

  p_send_cause_r5: assert property (@(posedge clk) disable iff (rst)
    send_valid |-> ($past(host_wr) && $past(host_wdata) == 8'h20
                    && $past(host_addr[STRIDE_LG-1:0]) == 8'h01));

  p_send_bound_r5: assert property (@(posedge clk) disable iff (rst)
    send_valid |-> send_len < 16'(MAX_LEN));

  p_send_sock_r1: assert property (@(posedge clk) disable iff (rst)
    send_valid |-> ((($past(host_addr) - ADDR_W'(SOCK_BASE)) >> STRIDE_LG) == ADDR_W'(send_sock)));
endmodule

bind socket_cmd_ctrl sockctl_chk #(
  .NUM_SOCK(NUM_SOCK), .ADDR_W(ADDR_W), .SOCK_BASE(SOCK_BASE),
  .STRIDE_LG(STRIDE_LG), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .send_valid(send_valid), .send_sock(send_sock), .send_len(send_len)
);

// File: tb/tb_socket_cmd_ctrl.sv
module tb_socket_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [15:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [7:0]  tx_size_code = '0, rx_size_code = '0;
  logic [63:0] rx_wr_ptr = '0;
  logic        send_valid;
  logic [1:0]  send_sock;
  logic [15:0] send_start, send_len;

  int total = 0, bad = 0, cycles = 0;
  logic [7:0]  m_mode [4];
  logic [7:0]  m_stat [4];
  logic [15:0] m_txr [4], m_txw [4], m_rxr [4], m_rsz [4], m_org [4];
  logic        s_valid;
  logic [1:0]  s_sock;
  logic [15:0] s_start, s_len;

  socket_cmd_ctrl dut (.*);

  always #2.5 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++; bad++;
        $display("FAIL watchdog: act=%0d exp<150000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  function automatic logic [15:0] rsize(input logic [7:0] codes, input int s);
    return 16'(1024) << codes[2*s +: 2];
  endfunction
  function automatic logic [15:0] rused(input logic [15:0] w, input logic [15:0] r, input logic [15:0] sz);
    return (w - r) & (sz - 16'd1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sa(input int s, input logic [7:0] off);
    return 16'h0400 + 16'(s) * 16'h0100 + 16'(off);
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    s_valid = send_valid; s_sock = send_sock; s_start = send_start; s_len = send_len;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic rd16(input int s, input logic [7:0] off, output logic [15:0] v);
    logic [7:0] h, l;
    rd(sa(s, off), h);
    rd(sa(s, off + 8'd1), l);
    v = {h, l};
  endtask

  task automatic wr16(input int s, input logic [7:0] off, input logic [15:0] v);
    wr(sa(s, off), v[15:8]);
    wr(sa(s, off + 8'd1), v[7:0]);
  endtask

  // command with model update; checks the send pulse (R5)
  task automatic cmd(input int s, input logic [7:0] c);
    logic [15:0] sz, exp_start, exp_len;
    logic        exp_fire;
    exp_fire = 1'b0; exp_start = '0; exp_len = '0;
    sz = rsize(tx_size_code, s);
    case (c)
      8'h01: begin
        if (m_mode[s][3:0] == 4'h3) m_stat[s] = 8'h32;
        else if (m_mode[s][3:0] == 4'h4) m_stat[s] = 8'h42;
        m_txr[s] = 0; m_txw[s] = 0; m_rxr[s] = 0; m_rsz[s] = 0;
        m_org[s] = rx_wr_ptr[16*s +: 16];
      end
      8'h10: m_stat[s] = 8'h00;
      8'h20: begin
        exp_fire  = (m_stat[s] == 8'h32 || m_stat[s] == 8'h42);
        exp_start = m_txr[s] & (sz - 16'd1);
        exp_len   = rused(m_txw[s], m_txr[s], sz);
        m_txr[s]  = m_txw[s];
      end
      8'h40: m_rsz[s] = rused(rx_wr_ptr[16*s +: 16] - m_org[s], m_rxr[s], rsize(rx_size_code, s));
      default: ;
    endcase
    wr(sa(s, 8'h01), c);
    check("R5 send_valid", int'(s_valid), int'(exp_fire));
    if (exp_fire) begin
      check("R5 send_sock", int'(s_sock), s);
      check("R5 send_start", int'(s_start), int'(exp_start));
      check("R5 send_len", int'(s_len), int'(exp_len));
      @(negedge clk);
      check("R5 pulse one cycle", int'(send_valid), 0);
    end
  endtask

  task automatic verify_sock(input int s);
    logic [7:0]  b;
    logic [15:0] v;
    rd(sa(s, 8'h03), b);  check("R3/R4 status", int'(b), int'(m_stat[s]));
    rd16(s, 8'h22, v);    check("R7 tx read ptr", int'(v), int'(m_txr[s]));
    rd16(s, 8'h24, v);    check("R7 tx write ptr", int'(v), int'(m_txw[s]));
    rd16(s, 8'h28, v);    check("R7 rx read ptr", int'(v), int'(m_rxr[s]));
    rd16(s, 8'h26, v);    check("R6 rx size", int'(v), int'(m_rsz[s]));
    rd16(s, 8'h20, v);
    check("R8 tx free", int'(v), int'(rsize(tx_size_code, s)
          - rused(m_txw[s], m_txr[s], rsize(tx_size_code, s))));
  endtask

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) begin
      m_mode[i] = 0; m_stat[i] = 0; m_txr[i] = 0; m_txw[i] = 0;
      m_rxr[i] = 0; m_rsz[i] = 0; m_org[i] = 0;
    end
    tx_size_code = 8'b11_10_01_00;
    rx_size_code = 8'b00_01_10_11;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    check("R9 rdata after reset", int'(host_rdata), 0);
    for (int s = 0; s < 4; s++) verify_sock(s);

    // R1 map and read-back
    wr(sa(1, 8'h00), 8'h04); m_mode[1] = 8'h04;
    rd(sa(1, 8'h00), b); check("R1 mode readback", int'(b), 8'h04);
    rd(sa(0, 8'h00), b); check("R1 neighbour mode", int'(b), 0);
    wr(sa(1, 8'h02), 8'h5A);
    rd(sa(1, 8'h02), b); check("R1 unused offset", int'(b), 0);
    wr(16'h0800, 8'h77);
    rd(16'h0800, b); check("R1 outside window", int'(b), 0);
    rd(16'h0300, b); check("R1 below window", int'(b), 0);

    // R2 idle rdata
    @(negedge clk); check("R2 idle rdata", int'(host_rdata), 0);

    // R3 open variants
    cmd(1, 8'h01); verify_sock(1);
    wr(sa(0, 8'h00), 8'hF3); m_mode[0] = 8'hF3;
    cmd(0, 8'h01); verify_sock(0);
    wr(sa(1, 8'h00), 8'h01); m_mode[1] = 8'h01;
    cmd(1, 8'h01); verify_sock(1);  // TCP: status stays 0x42

    // R7 tx read pointer read-only
    wr16(1, 8'h22, 16'h1234);
    wr16(1, 8'h24, 16'h0500); m_txw[1] = 16'h0500;
    verify_sock(1);

    // R5 send on raw socket
    cmd(1, 8'h20); verify_sock(1);
    // wrap: write pointer below read pointer
    wr16(1, 8'h24, 16'h0100); m_txw[1] = 16'h0100;
    verify_sock(1);
    cmd(1, 8'h20); verify_sock(1);

    // R4 close, then R5 send on closed socket
    cmd(1, 8'h10); verify_sock(1);
    wr16(1, 8'h24, 16'h0333); m_txw[1] = 16'h0333;
    cmd(1, 8'h20); verify_sock(1);

    // R6 receive snapshot
    rx_wr_ptr[16*0 +: 16] = 16'h0040;
    cmd(0, 8'h40); verify_sock(0);
    rx_wr_ptr[16*0 +: 16] = 16'h0100;
    verify_sock(0);  // RSR still the old snapshot
    wr16(0, 8'h28, 16'h1F00); m_rxr[0] = 16'h1F00;
    cmd(0, 8'h40); verify_sock(0);  // wrap across size 8192

    // R10 unknown command
    cmd(0, 8'h08);
    rd(sa(0, 8'h01), b); check("R10 cmd stored", int'(b), 8'h08);
    verify_sock(0);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int s, op;
      s  = int'($urandom_range(0, 3));
      op = int'($urandom_range(0, 6));
      case (op)
        0: begin m_txw[s] = 16'($urandom); wr16(s, 8'h24, m_txw[s]); end
        1: begin m_rxr[s] = 16'($urandom); wr16(s, 8'h28, m_rxr[s]); end
        2: begin m_mode[s] = 8'($urandom_range(0, 5)); wr(sa(s, 8'h00), m_mode[s]); end
        3: cmd(s, 8'h01);
        4: cmd(s, 8'h20);
        5: begin rx_wr_ptr[16*s +: 16] = 16'($urandom); cmd(s, 8'h40); end
        default: begin
          @(negedge clk);
          tx_size_code = 8'($urandom); rx_size_code = 8'($urandom);
          cmd(s, 8'h10);
        end
      endcase
      if (it % 10 == 0) verify_sock(s);
      else begin
        rd16(s, 8'h20, v);
        check("R8 tx free random", int'(v), int'(rsize(tx_size_code, s)
              - rused(m_txw[s], m_txr[s], rsize(tx_size_code, s))));
      end
    end
    for (int s = 0; s < 4; s++) verify_sock(s);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule